// File: doc/BRIEF.md
# Bidirectional FIFO Port Controller with Mailbox

This block holds the control logic for one side of a buffer made of two FIFOs, one for each direction. The port has one 36-bit shared data bus and four strobes: an active-low chip select, a direction select, an enable, and a mailbox select. From these strobes the block decodes one of four actions on each rising clock edge:

- push the bus word into the outgoing FIFO,
- pop a word from the incoming FIFO,
- store the bus word in the outgoing single-word mailbox,
- fetch the word held in the incoming mailbox.

It also drives the output enable of the shared bus. It keeps the full flag of the outgoing mailbox, which is active low.

The FIFO memories and the synchronisers between the two clock domains sit outside this block. The block sees the outgoing FIFO through a write strobe and an input-ready flag. It sees the incoming FIFO through a read strobe, an output-ready flag and a data word that shows the head entry. The incoming mailbox comes from the far-side controller as a data word. The block answers with a one-cycle pulse when that mailbox is read.

Two copies of the block make a full bidirectional buffer. One copy reads when its direction input is low, and the other reads when its direction input is high. A parameter selects the polarity.

Top module: `bififo_port_ctrl`

## Requirements
- R1: `bus_oe` is high exactly when `cs_n` is low and `dir` equals the read level. The read level is `READ_LEVEL`: 0 means a low `dir` reads, and 1 means a high `dir` reads. It is combinational.
- R2: When `cs_n`=0, `dir` selects write, `en`=1, `mbx_sel`=0 and `ofifo_in_rdy`=1, then `ofifo_wr_en` is 1 in that same cycle and `ofifo_wr_data` equals `bus_in`.
- R3: When `cs_n`=0, `dir` selects read, `en`=1, `mbx_sel`=0 and `ififo_out_rdy`=1, then `ififo_rd_en` is 1 in that cycle. After the clock edge, `bus_out` holds the `ififo_rd_data` value that was present at the edge.
- R4: When `cs_n`=1 or `en`=0, none of `ofifo_wr_en`, `ififo_rd_en` or `mbx_in_rd` is asserted.
- R5: A write with `mbx_sel`=1 while `mbx_out_flag_n`=1 stores `bus_in` into `mbx_out_data` and drives `mbx_out_flag_n` low after the edge. No FIFO write happens.
- R6: A mailbox write while `mbx_out_flag_n`=0 is ignored, and `mbx_out_data` keeps its old value.
- R7: A `far_mbx_rd` pulse sets `mbx_out_flag_n` high after the edge, unless a local mailbox write is accepted in the same cycle. In that case the write wins.
- R8: A read with `mbx_sel`=1 pulses `mbx_in_rd` and does not pulse `ififo_rd_en`. After the edge, `bus_out` holds `mbx_in_data`.
- R9: While `rst_n` is low, `mbx_out_flag_n` is 1, and `mbx_out_data` and `bus_out` are 0. The reset is asynchronous and applies even when the mailbox is full.
- R10: The block follows the polarity set by `READ_LEVEL`. A `dir` value that reads on a side with `READ_LEVEL`=0 writes on a side with `READ_LEVEL`=1, and the reverse also holds.
- R11: If the needed ready flag is low, the FIFO access does not happen: no strobe is asserted, and `bus_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset of this side |
| cs_n | input | 1 | Active-low chip select |
| dir | input | 1 | Direction select; its read level is set by READ_LEVEL |
| en | input | 1 | Access enable |
| mbx_sel | input | 1 | Steers the access to the mailbox |
| bus_in | input | DATA_W | Word from the shared bus |
| bus_out | output | DATA_W | Registered read word for the shared bus |
| bus_oe | output | 1 | Output enable for the bus drivers |
| ofifo_in_rdy | input | 1 | Outgoing FIFO can accept a word |
| ofifo_wr_en | output | 1 | Write strobe to the outgoing FIFO |
| ofifo_wr_data | output | DATA_W | Word written to the outgoing FIFO |
| ififo_out_rdy | input | 1 | Incoming FIFO has a word |
| ififo_rd_data | input | DATA_W | Head word of the incoming FIFO |
| ififo_rd_en | output | 1 | Read strobe to the incoming FIFO |
| mbx_out_data | output | DATA_W | Outgoing mailbox contents |
| mbx_out_flag_n | output | 1 | Outgoing mailbox flag; low means full |
| far_mbx_rd | input | 1 | Far side read the outgoing mailbox |
| mbx_in_data | input | DATA_W | Incoming mailbox word from the far side |
| mbx_in_rd | output | 1 | Pulse telling the far side its mailbox was read |

## Verification
The bench runs one side of each polarity on the same strobes. A design that swapped the polarity would show the read and write strobes, and the bus enable, on the wrong instance.

The bench tries a second mailbox write while the mailbox is full. A design that still accepted writes would overwrite the pending word before the far side fetched it.

The bench holds each ready flag low during an access. A design that ignored the flag would pulse a strobe, or would reload `bus_out` with stale head data.

The bench asserts reset while the mailbox is full. A design whose flag did not clear on reset would block the first mailbox write after the reset.

// File: rtl/bififo_port_pkg.sv
package bififo_port_pkg;
   typedef enum logic [2:0] {
      ACC_IDLE    = 3'd0,
      ACC_FIFO_WR = 3'd1,
      ACC_FIFO_RD = 3'd2,
      ACC_MBX_WR  = 3'd3,
      ACC_MBX_RD  = 3'd4
   } acc_e;
endpackage

// File: rtl/bififo_strobe_decode.sv
module bififo_strobe_decode
   import bififo_port_pkg::*;
#(
   parameter int READ_LEVEL = 0
) (
   input  logic cs_n,
   input  logic dir,
   input  logic en,
   input  logic mbx_sel,
   input  logic in_rdy,
   input  logic out_rdy,
   input  logic mbx_free,
   output acc_e acc,
   output logic rd_dir
);
   generate
      if (READ_LEVEL == 0) begin : g_rd_low
         assign rd_dir = ~dir;
      end else begin : g_rd_high
         assign rd_dir = dir;
      end
   endgenerate

   always_comb begin
      acc = ACC_IDLE;
      if (!cs_n && en) begin
         if (rd_dir) begin
            if (mbx_sel)      acc = ACC_MBX_RD;
            else if (out_rdy) acc = ACC_FIFO_RD;
         end else begin
            if (mbx_sel) begin
               if (mbx_free)  acc = ACC_MBX_WR;
            end else if (in_rdy) begin
               acc = ACC_FIFO_WR;
            end
         end
      end
   end
endmodule

// File: rtl/bififo_mailbox_reg.sv
module bififo_mailbox_reg #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              far_rd,
   output logic [DATA_W-1:0] data,
   output logic              flag_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data   <= '0;
         flag_n <= 1'b1;
      end else begin
         if (wr) begin
            data   <= wr_data;
            flag_n <= 1'b0;
         end else if (far_rd) begin
            flag_n <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/bififo_rd_path.sv
module bififo_rd_path #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_fifo,
   input  logic              ld_mbx,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic [DATA_W-1:0] mbx_data,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (ld_mbx)  q <= mbx_data;
      else if (ld_fifo) q <= fifo_data;
   end
endmodule

// File: rtl/bififo_port_ctrl.sv
module bififo_port_ctrl
   import bififo_port_pkg::*;
#(
   parameter int DATA_W     = 36,
   parameter int READ_LEVEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              dir,
   input  logic              en,
   input  logic              mbx_sel,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic              ofifo_in_rdy,
   output logic              ofifo_wr_en,
   output logic [DATA_W-1:0] ofifo_wr_data,
   input  logic              ififo_out_rdy,
   input  logic [DATA_W-1:0] ififo_rd_data,
   output logic              ififo_rd_en,
   output logic [DATA_W-1:0] mbx_out_data,
   output logic              mbx_out_flag_n,
   input  logic              far_mbx_rd,
   input  logic [DATA_W-1:0] mbx_in_data,
   output logic              mbx_in_rd
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (READ_LEVEL != 0 && READ_LEVEL != 1) begin : g_bad_level
         $error("READ_LEVEL must be 0 or 1");
      end
   endgenerate

   acc_e acc;
   logic rd_dir;

   bififo_strobe_decode #(.READ_LEVEL(READ_LEVEL)) dec_i (
      .cs_n     (cs_n),
      .dir      (dir),
      .en       (en),
      .mbx_sel  (mbx_sel),
      .in_rdy   (ofifo_in_rdy),
      .out_rdy  (ififo_out_rdy),
      .mbx_free (mbx_out_flag_n),
      .acc      (acc),
      .rd_dir   (rd_dir)
   );

   assign bus_oe        = !cs_n && rd_dir;
   assign ofifo_wr_en   = (acc == ACC_FIFO_WR);
   assign ofifo_wr_data = bus_in;
   assign ififo_rd_en   = (acc == ACC_FIFO_RD);
   assign mbx_in_rd     = (acc == ACC_MBX_RD);

   bififo_mailbox_reg #(.DATA_W(DATA_W)) mbx_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (acc == ACC_MBX_WR),
      .wr_data (bus_in),
      .far_rd  (far_mbx_rd),
      .data    (mbx_out_data),
      .flag_n  (mbx_out_flag_n)
   );

   bififo_rd_path #(.DATA_W(DATA_W)) rdp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_fifo   (ififo_rd_en),
      .ld_mbx    (mbx_in_rd),
      .fifo_data (ififo_rd_data),
      .mbx_data  (mbx_in_data),
      .q         (bus_out)
   );
endmodule

// File: rtl/bififo_port_ctrl_chk.sv
module bififo_port_ctrl_chk #(
   parameter int DATA_W     = 36,
   parameter int READ_LEVEL = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              dir,
   input logic              en,
   input logic              mbx_sel,
   input logic [DATA_W-1:0] bus_in,
   input logic [DATA_W-1:0] bus_out,
   input logic              bus_oe,
   input logic              ofifo_in_rdy,
   input logic              ofifo_wr_en,
   input logic              ififo_out_rdy,
   input logic [DATA_W-1:0] ififo_rd_data,
   input logic              ififo_rd_en,
   input logic [DATA_W-1:0] mbx_out_data,
   input logic              mbx_out_flag_n,
   input logic              far_mbx_rd,
   input logic [DATA_W-1:0] mbx_in_data,
   input logic              mbx_in_rd
);
   localparam logic RD_LVL = (READ_LEVEL != 0);
   logic wr_dir;
   assign wr_dir = (dir != RD_LVL);

   a_r1_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !cs_n);
   a_r2_wr_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ofifo_wr_en |-> (ofifo_in_rdy && !mbx_sel && wr_dir));
   a_r3_rd_loads_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (ififo_rd_en && !mbx_in_rd) |=> (bus_out == $past(ififo_rd_data)));
   a_r4_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !en) |-> !(ofifo_wr_en || ififo_rd_en || mbx_in_rd));
   a_r5_mbx_wr_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && en && mbx_sel && wr_dir && mbx_out_flag_n)
      |=> (!mbx_out_flag_n && mbx_out_data == $past(bus_in)));
   a_r6_full_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
      !mbx_out_flag_n |=> $stable(mbx_out_data));
   a_r7_flag_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mbx_out_flag_n) |-> $past(far_mbx_rd));
   a_r8_mbx_rd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      mbx_in_rd |-> !(ififo_rd_en || ofifo_wr_en));
   a_r8_mbx_rd_data: assert property (@(posedge clk) disable iff (!rst_n)
      mbx_in_rd |=> (bus_out == $past(mbx_in_data)));
   a_r11_hold_without_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (!ififo_rd_en && !mbx_in_rd) |=> $stable(bus_out));
endmodule

bind bififo_port_ctrl bififo_port_ctrl_chk #(.DATA_W(DATA_W), .READ_LEVEL(READ_LEVEL)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .cs_n           (cs_n),
   .dir            (dir),
   .en             (en),
   .mbx_sel        (mbx_sel),
   .bus_in         (bus_in),
   .bus_out        (bus_out),
   .bus_oe         (bus_oe),
   .ofifo_in_rdy   (ofifo_in_rdy),
   .ofifo_wr_en    (ofifo_wr_en),
   .ififo_out_rdy  (ififo_out_rdy),
   .ififo_rd_data  (ififo_rd_data),
   .ififo_rd_en    (ififo_rd_en),
   .mbx_out_data   (mbx_out_data),
   .mbx_out_flag_n (mbx_out_flag_n),
   .far_mbx_rd     (far_mbx_rd),
   .mbx_in_data    (mbx_in_data),
   .mbx_in_rd      (mbx_in_rd)
);

// File: tb/bififo_port_ctrl_tb_top.sv
module bififo_port_ctrl_tb_top;
   localparam int  W        = 36;
   localparam time CLK_HALF = 5ns;
   localparam int  WDOG_CYC = 5000;

   logic clk = 1'b0;
   logic rst_n, cs_n, dir, en, mbx_sel, in_rdy, out_rdy, far_rd;
   logic [W-1:0] bus_in, rd_data, mbx_in;

   logic [W-1:0] a_bus_out, a_wr_data, a_mbx_data;
   logic a_oe, a_wr_en, a_rd_en, a_flag, a_mbx_rd;
   logic [W-1:0] b_bus_out, b_wr_data, b_mbx_data;
   logic b_oe, b_wr_en, b_rd_en, b_flag, b_mbx_rd;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_HALF) clk = ~clk;

   bififo_port_ctrl #(.DATA_W(W), .READ_LEVEL(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dir(dir), .en(en), .mbx_sel(mbx_sel),
      .bus_in(bus_in), .bus_out(a_bus_out), .bus_oe(a_oe),
      .ofifo_in_rdy(in_rdy), .ofifo_wr_en(a_wr_en), .ofifo_wr_data(a_wr_data),
      .ififo_out_rdy(out_rdy), .ififo_rd_data(rd_data), .ififo_rd_en(a_rd_en),
      .mbx_out_data(a_mbx_data), .mbx_out_flag_n(a_flag), .far_mbx_rd(far_rd),
      .mbx_in_data(mbx_in), .mbx_in_rd(a_mbx_rd));

   bififo_port_ctrl #(.DATA_W(W), .READ_LEVEL(1)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dir(dir), .en(en), .mbx_sel(mbx_sel),
      .bus_in(bus_in), .bus_out(b_bus_out), .bus_oe(b_oe),
      .ofifo_in_rdy(in_rdy), .ofifo_wr_en(b_wr_en), .ofifo_wr_data(b_wr_data),
      .ififo_out_rdy(out_rdy), .ififo_rd_data(rd_data), .ififo_rd_en(b_rd_en),
      .mbx_out_data(b_mbx_data), .mbx_out_flag_n(b_flag), .far_mbx_rd(far_rd),
      .mbx_in_data(mbx_in), .mbx_in_rd(b_mbx_rd));

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic c, input logic d, input logic e, input logic m);
      cs_n = c; dir = d; en = e; mbx_sel = m;
   endtask

   task automatic idle();
      drive(1'b1, 1'b0, 1'b0, 1'b0);
      far_rd = 1'b0;
   endtask

   // advance one rising edge, return at the following falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; idle();
      in_rdy = 1'b0; out_rdy = 1'b0; bus_in = '0; rd_data = '0; mbx_in = '0;
      step(); step();
      check("R9 flag in reset", W'(a_flag), W'(1));
      check("R9 mailbox data in reset", a_mbx_data, '0);
      check("R9 bus_out in reset", a_bus_out, '0);
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_oe();
      for (int i = 0; i < 4; i++) begin
         drive(i[1], i[0], 1'b0, 1'b0);
         #1;
         check("R1 oe read-low side", W'(a_oe), W'(!i[1] && !i[0]));
         check("R10 oe read-high side", W'(b_oe), W'(!i[1] && i[0]));
      end
      idle();
      step();
   endtask

   task automatic t_fifo_wr();
      in_rdy = 1'b1; out_rdy = 1'b1; bus_in = 36'h9_1234_5678;
      drive(1'b0, 1'b1, 1'b1, 1'b0);
      #1;
      check("R2 wr strobe", W'(a_wr_en), W'(1));
      check("R2 wr data", a_wr_data, 36'h9_1234_5678);
      check("R10 same dir reads on other side", W'(b_rd_en), W'(1));
      check("R10 other side no write", W'(b_wr_en), W'(0));
      in_rdy = 1'b0; #1;
      check("R11 write blocked by input-ready", W'(a_wr_en), W'(0));
      in_rdy = 1'b1; en = 1'b0; #1;
      check("R4 enable low no write", W'(a_wr_en), W'(0));
      en = 1'b1; cs_n = 1'b1; #1;
      check("R4 deselected no write", W'(a_wr_en), W'(0));
      check("R4 deselected no read", W'(b_rd_en), W'(0));
      idle();
      step();
   endtask

   task automatic t_fifo_rd();
      out_rdy = 1'b1; rd_data = 36'hA_BCDE_0123;
      drive(1'b0, 1'b0, 1'b1, 1'b0);
      #1;
      check("R3 rd strobe", W'(a_rd_en), W'(1));
      step();
      check("R3 bus_out after read", a_bus_out, 36'hA_BCDE_0123);
      out_rdy = 1'b0; rd_data = 36'h5_5555_5555;
      #1;
      check("R11 read blocked by output-ready", W'(a_rd_en), W'(0));
      step();
      check("R11 bus_out holds", a_bus_out, 36'hA_BCDE_0123);
      idle();
      step();
   endtask

   task automatic t_mbx();
      out_rdy = 1'b1; in_rdy = 1'b1;
      bus_in = 36'h1_0000_00AA;
      drive(1'b0, 1'b1, 1'b1, 1'b1);
      #1;
      check("R5 mailbox write no fifo write", W'(a_wr_en), W'(0));
      step();
      check("R5 flag low after write", W'(a_flag), W'(0));
      check("R5 mailbox data", a_mbx_data, 36'h1_0000_00AA);
      bus_in = 36'h2_0000_00BB;
      step();
      check("R6 full mailbox keeps data", a_mbx_data, 36'h1_0000_00AA);
      idle(); far_rd = 1'b1;
      step();
      far_rd = 1'b0;
      check("R7 far read frees flag", W'(a_flag), W'(1));
      drive(1'b0, 1'b1, 1'b1, 1'b1); far_rd = 1'b1;
      step();
      check("R7 local write wins over far read", W'(a_flag), W'(0));
      check("R7 data taken", a_mbx_data, 36'h2_0000_00BB);
      idle();
      mbx_in = 36'hC_0FFE_E000; rd_data = 36'h0_0000_0001;
      drive(1'b0, 1'b0, 1'b1, 1'b1);
      #1;
      check("R8 mailbox read pulse", W'(a_mbx_rd), W'(1));
      check("R8 no fifo read", W'(a_rd_en), W'(0));
      step();
      check("R8 bus_out from mailbox", a_bus_out, 36'hC_0FFE_E000);
      idle();
      step();
   endtask

   task automatic t_reset_full();
      check("R9 mailbox full before reset", W'(a_flag), W'(0));
      #1 rst_n = 1'b0;
      #1;
      check("R9 reset frees full mailbox", W'(a_flag), W'(1));
      check("R9 reset clears bus_out", a_bus_out, '0);
      step();
      rst_n = 1'b1;
      step();
   endtask

   initial begin
      t_reset();
      t_oe();
      t_fifo_wr();
      t_fifo_rd();
      t_mbx();
      t_reset_full();
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WDOG_CYC) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WDOG_CYC);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule